// File: doc/BRIEF.md
# Bitwise Logic Execution Unit

This unit performs the bit-parallel logical operations of a 64-bit integer pipeline. It takes two source operands, a 16-bit unsigned immediate, a 5-bit operation code and a record flag. It returns a destination value and, for operations that record their outcome, a 4-bit condition field. The operations are:

- eight two-register bitwise forms;
- three immediate forms, with the immediate at the bottom of the word;
- three shifted-immediate forms;
- three sign-extension forms.

The result and the condition field are registered, so they appear one cycle after the operation is presented. A valid flag travels alongside them. Decode, register-file access, carry and overflow tracking, and hazard handling belong to neighbouring blocks.

The condition field reports how the 64-bit result compares with zero as a signed number. It also carries a copy of the summary-overflow input, which this unit never alters. Operation codes 0 to 16 are defined. Codes 17 to 31 are reserved.

Top module: `bitwise_exec_unit`

## Requirements
- R1: Codes 0 to 7 produce srcA&srcB, srcA|srcB, srcA^srcB, ~(srcA&srcB), ~(srcA|srcB), ~(srcA^srcB), srcA&~srcB and srcA|~srcB, in that code order.
- R2: Codes 8, 9 and 10 combine srcA with the immediate, zero-extended into bits 15:0, by AND, OR and XOR respectively.
- R3: Codes 11, 12 and 13 combine srcA with the immediate placed in bits 31:16, with every other bit zero, by AND, OR and XOR respectively.
- R4: Codes 14, 15 and 16 copy the low 8, 16 or 32 bits of srcA and fill all higher bits with the top bit of that field.
- R5: For codes 0 to 7 and 14 to 16, crWrite is raised with the result only when recordBit was 1.
- R6: Codes 8 and 11 always raise crWrite, whatever the value of recordBit.
- R7: Codes 9, 10, 12 and 13 never raise crWrite, even with recordBit set.
- R8: When crWrite is high, crOut is {LT, GT, EQ, SO}. LT, GT and EQ give the signed comparison of resultOut with zero, and SO (bit 0) copies sumOvIn. When a valid operation does not record, crOut is 0.
- R9: The outputs appear one clock after validIn is high, and validOut follows validIn with that one-cycle delay. When validIn is low, validOut and crWrite are 0 on the next cycle and resultOut and crOut keep their values.
- R10: A reserved code (17 to 31) gives resultOut 0 and never raises crWrite.
- R11: While reset is asserted, validOut, crWrite, resultOut and crOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| validIn | input | 1 | Operation presented this cycle |
| opSel | input | 5 | Operation code |
| srcA | input | 64 | First source operand |
| srcB | input | 64 | Second source operand |
| immVal | input | 16 | Unsigned immediate |
| recordBit | input | 1 | Request a condition-field update (register and extension forms) |
| sumOvIn | input | 1 | Summary-overflow status copied into the condition field |
| validOut | output | 1 | Result valid |
| resultOut | output | 64 | Destination value |
| crOut | output | 4 | Condition field {LT, GT, EQ, SO} |
| crWrite | output | 1 | Condition field should be written |

## Verification
The assertions assume that validIn, opSel, recordBit and sumOvIn never carry unknown values while out of reset, and that validIn stays low during reset. The bench satisfies this by driving every input to a defined value on the falling clock edge, starting before reset is released. Random operands are drawn from several patterns: fully random values, zero, equal operands, and values near sign boundaries. These make sure the EQ, LT and GT outcomes and the sign-extension fill bits are all reached, alongside directed cases for recordBit on the forms that ignore it.

// File: rtl/bwu_pkg.sv
package bwu_pkg;

  typedef enum logic [4:0] {
    OP_AND   = 5'd0,
    OP_OR    = 5'd1,
    OP_XOR   = 5'd2,
    OP_NAND  = 5'd3,
    OP_NOR   = 5'd4,
    OP_EQV   = 5'd5,
    OP_ANDC  = 5'd6,
    OP_ORC   = 5'd7,
    OP_ANDI  = 5'd8,
    OP_ORI   = 5'd9,
    OP_XORI  = 5'd10,
    OP_ANDIS = 5'd11,
    OP_ORIS  = 5'd12,
    OP_XORIS = 5'd13,
    OP_EXTB  = 5'd14,
    OP_EXTH  = 5'd15,
    OP_EXTW  = 5'd16
  } opCodeE;

  typedef enum logic [1:0] {
    FN_AND = 2'd0,
    FN_OR  = 2'd1,
    FN_XOR = 2'd2
  } logicFnE;

  typedef enum logic [1:0] {
    EXT_NONE = 2'd0,
    EXT_BYTE = 2'd1,
    EXT_HALF = 2'd2,
    EXT_WORD = 2'd3
  } extSelE;

  typedef struct packed {
    logic    load;
    logicFnE fn;
    logic    invB;
    logic    invOut;
    logic    useImm;
    logic    immShift;
    extSelE  ext;
    logic    crEn;
    logic    zeroOut;
  } strobeT;

endpackage

// File: rtl/bwu_ctrl.sv
module bwu_ctrl
  import bwu_pkg::*;
(
  input  logic       validIn,
  input  logic [4:0] opSel,
  input  logic       recordBit,
  output strobeT     strobe
);

  always_comb begin
    strobe          = '0;
    strobe.load     = validIn;
    strobe.fn       = FN_AND;
    strobe.ext      = EXT_NONE;
    strobe.zeroOut  = 1'b0;
    strobe.crEn     = recordBit;
    case (opSel)
      OP_AND:   strobe.fn = FN_AND;
      OP_OR:    strobe.fn = FN_OR;
      OP_XOR:   strobe.fn = FN_XOR;
      OP_NAND:  begin strobe.fn = FN_AND; strobe.invOut = 1'b1; end
      OP_NOR:   begin strobe.fn = FN_OR;  strobe.invOut = 1'b1; end
      OP_EQV:   begin strobe.fn = FN_XOR; strobe.invOut = 1'b1; end
      OP_ANDC:  begin strobe.fn = FN_AND; strobe.invB = 1'b1; end
      OP_ORC:   begin strobe.fn = FN_OR;  strobe.invB = 1'b1; end
      OP_ANDI:  begin strobe.fn = FN_AND; strobe.useImm = 1'b1; strobe.crEn = 1'b1; end
      OP_ORI:   begin strobe.fn = FN_OR;  strobe.useImm = 1'b1; strobe.crEn = 1'b0; end
      OP_XORI:  begin strobe.fn = FN_XOR; strobe.useImm = 1'b1; strobe.crEn = 1'b0; end
      OP_ANDIS: begin
        strobe.fn = FN_AND; strobe.useImm = 1'b1; strobe.immShift = 1'b1; strobe.crEn = 1'b1;
      end
      OP_ORIS:  begin
        strobe.fn = FN_OR;  strobe.useImm = 1'b1; strobe.immShift = 1'b1; strobe.crEn = 1'b0;
      end
      OP_XORIS: begin
        strobe.fn = FN_XOR; strobe.useImm = 1'b1; strobe.immShift = 1'b1; strobe.crEn = 1'b0;
      end
      OP_EXTB:  strobe.ext = EXT_BYTE;
      OP_EXTH:  strobe.ext = EXT_HALF;
      OP_EXTW:  strobe.ext = EXT_WORD;
      default:  begin strobe.zeroOut = 1'b1; strobe.crEn = 1'b0; end
    endcase
  end

endmodule

// File: rtl/bwu_datapath.sv
module bwu_datapath
  import bwu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              sumOvIn,
  output logic              validQ,
  output logic [DATA_W-1:0] resultQ,
  output logic [3:0]        crQ,
  output logic              crWriteQ
);

  localparam int HI_PAD  = DATA_W - 2 * IMM_W;
  localparam int LO_PAD  = DATA_W - IMM_W;
  localparam int EXT_CNT = 3;

  logic [DATA_W-1:0] immLow;
  logic [DATA_W-1:0] immHigh;
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] logicRaw;
  logic [DATA_W-1:0] logicOut;
  logic [DATA_W-1:0] extVal [EXT_CNT];
  logic [DATA_W-1:0] resultNext;
  logic [3:0]        crNext;
  logic              resZero;
  logic              resNeg;

  assign immLow  = {{LO_PAD{1'b0}}, immVal};
  assign immHigh = {{HI_PAD{1'b0}}, immVal, {IMM_W{1'b0}}};

  always_comb begin
    if (strobe.useImm) operandB = strobe.immShift ? immHigh : immLow;
    else               operandB = srcB;
    if (strobe.invB)   operandB = ~operandB;
  end

  always_comb begin
    case (strobe.fn)
      FN_OR:   logicRaw = srcA | operandB;
      FN_XOR:  logicRaw = srcA ^ operandB;
      default: logicRaw = srcA & operandB;
    endcase
    logicOut = strobe.invOut ? ~logicRaw : logicRaw;
  end

  for (genvar g = 0; g < EXT_CNT; g++) begin : gExt
    localparam int FW = DATA_W >> (EXT_CNT - g);
    assign extVal[g] = {{(DATA_W - FW){srcA[FW-1]}}, srcA[FW-1:0]};
  end

  always_comb begin
    case (strobe.ext)
      EXT_BYTE: resultNext = extVal[0];
      EXT_HALF: resultNext = extVal[1];
      EXT_WORD: resultNext = extVal[2];
      default:  resultNext = logicOut;
    endcase
    if (strobe.zeroOut) resultNext = '0;
  end

  assign resZero = (resultNext == '0);
  assign resNeg  = resultNext[DATA_W-1];
  assign crNext  = {resNeg, ~resNeg & ~resZero, resZero, sumOvIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      resultQ  <= '0;
      crQ      <= '0;
      crWriteQ <= 1'b0;
    end else begin
      validQ <= strobe.load;
      if (strobe.load) begin
        resultQ  <= resultNext;
        crWriteQ <= strobe.crEn;
        crQ      <= strobe.crEn ? crNext : 4'b0000;
      end
    end
  end

endmodule

// File: rtl/bitwise_exec_unit.sv
module bitwise_exec_unit
  import bwu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [4:0]        opSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              recordBit,
  input  logic              sumOvIn,
  output logic              validOut,
  output logic [DATA_W-1:0] resultOut,
  output logic [3:0]        crOut,
  output logic              crWrite
);

  strobeT strobe;
  logic   crWriteQ;

  bwu_ctrl i_ctrl (
    .validIn   (validIn),
    .opSel     (opSel),
    .recordBit (recordBit),
    .strobe    (strobe)
  );

  bwu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srcA     (srcA),
    .srcB     (srcB),
    .immVal   (immVal),
    .sumOvIn  (sumOvIn),
    .validQ   (validOut),
    .resultQ  (resultOut),
    .crQ      (crOut),
    .crWriteQ (crWriteQ)
  );

  assign crWrite = validOut & crWriteQ;

endmodule

// File: rtl/bitwise_exec_unit_chk.sv
module bitwise_exec_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [4:0]        opSel,
  input logic              sumOvIn,
  input logic              validOut,
  input logic [DATA_W-1:0] resultOut,
  input logic [3:0]        crOut,
  input logic              crWrite
);

  logic noCrOp;
  logic andImmOp;
  logic reservedOp;
  assign noCrOp     = (opSel == 5'd9) || (opSel == 5'd10) || (opSel == 5'd12) || (opSel == 5'd13);
  assign andImmOp   = (opSel == 5'd8) || (opSel == 5'd11);
  assign reservedOp = (opSel > 5'd16);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!validOut && !crWrite && $stable(resultOut) && $stable(crOut))); // R9
  AST_OR_XOR_IMM_NO_CR: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && noCrOp) |=> !crWrite); // R7
  AST_AND_IMM_CR: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && andImmOp) |=> crWrite); // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && reservedOp) |=> (!crWrite && resultOut == '0)); // R10
  AST_CR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    crWrite |-> $onehot(crOut[3:1])); // R8
  AST_CR_EQ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    crWrite |-> (crOut[1] == (resultOut == '0))); // R8
  AST_CR_LT_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    crWrite |-> (crOut[3] == resultOut[DATA_W-1])); // R8
  AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> (!crWrite || crOut[0] == $past(sumOvIn))); // R8

endmodule

bind bitwise_exec_unit bitwise_exec_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .opSel     (opSel),
  .sumOvIn   (sumOvIn),
  .validOut  (validOut),
  .resultOut (resultOut),
  .crOut     (crOut),
  .crWrite   (crWrite)
);

// File: tb/test_bitwise_exec_unit.sv
module test_bitwise_exec_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        validIn;
  logic [4:0]  opSel;
  logic [63:0] srcA;
  logic [63:0] srcB;
  logic [15:0] immVal;
  logic        recordBit;
  logic        sumOvIn;
  logic        validOut;
  logic [63:0] resultOut;
  logic [3:0]  crOut;
  logic        crWrite;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitwise_exec_unit i_bitwise_exec_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opSel(opSel), .srcA(srcA), .srcB(srcB),
    .immVal(immVal), .recordBit(recordBit), .sumOvIn(sumOvIn), .validOut(validOut),
    .resultOut(resultOut), .crOut(crOut), .crWrite(crWrite)
  );

  function automatic logic [63:0] expRes(int op, logic [63:0] a, logic [63:0] b, logic [15:0] imm);
    logic [63:0] lo = {48'h0, imm};
    logic [63:0] hi = {32'h0, imm, 16'h0};
    case (op)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return ~(a & b);
      4: return ~(a | b);
      5: return ~(a ^ b);
      6: return a & ~b;
      7: return a | ~b;
      8: return a & lo;
      9: return a | lo;
      10: return a ^ lo;
      11: return a & hi;
      12: return a | hi;
      13: return a ^ hi;
      14: return {{56{a[7]}}, a[7:0]};
      15: return {{48{a[15]}}, a[15:0]};
      16: return {{32{a[31]}}, a[31:0]};
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic expCrW(int op, logic rc);
    if (op <= 7 || (op >= 14 && op <= 16)) return rc;
    if (op == 8 || op == 11) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string resTag(int op);
    if (op <= 7) return "R1";
    if (op <= 10) return "R2";
    if (op <= 13) return "R3";
    if (op <= 16) return "R4";
    return "R10";
  endfunction

  function automatic string crTag(int op);
    if (op == 8 || op == 11) return "R6";
    if (op == 9 || op == 10 || op == 12 || op == 13) return "R7";
    if (op > 16) return "R10";
    return "R5";
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(int op, logic [63:0] a, logic [63:0] b, logic [15:0] imm, logic rc, logic so);
    logic [63:0] r;
    logic        w;
    logic [3:0]  c;
    validIn = 1'b1; opSel = op[4:0]; srcA = a; srcB = b; immVal = imm;
    recordBit = rc; sumOvIn = so;
    r = expRes(op, a, b, imm);
    w = expCrW(op, rc);
    c = w ? {$signed(r) < 0, $signed(r) > 0, r == 64'h0, so} : 4'b0000;
    @(negedge clk);
    chk("R9", "validOut", {63'h0, validOut}, 64'h1);
    chk(resTag(op), "resultOut", resultOut, r);
    chk(crTag(op), "crWrite", {63'h0, crWrite}, {63'h0, w});
    chk("R8", "crOut", {60'h0, crOut}, {60'h0, c});
  endtask

  task automatic idleCycle();
    logic [63:0] prevRes = resultOut;
    logic [3:0]  prevCr  = crOut;
    validIn = 1'b0; opSel = 5'd8; srcA = {$urandom, $urandom}; srcB = ~srcA;
    immVal = 16'hFFFF; recordBit = 1'b1; sumOvIn = 1'b1;
    @(negedge clk);
    chk("R9", "idle validOut", {63'h0, validOut}, 64'h0);
    chk("R9", "idle crWrite", {63'h0, crWrite}, 64'h0);
    chk("R9", "idle resultOut held", resultOut, prevRes);
    chk("R9", "idle crOut held", {60'h0, crOut}, {60'h0, prevCr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; validIn = 1'b0; opSel = '0; srcA = '1; srcB = '1;
    immVal = '1; recordBit = 1'b1; sumOvIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "reset validOut", {63'h0, validOut}, 64'h0);
    chk("R11", "reset crWrite", {63'h0, crWrite}, 64'h0);
    chk("R11", "reset resultOut", resultOut, 64'h0);
    chk("R11", "reset crOut", {60'h0, crOut}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    runOp(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0, 1'b1, 1'b0);          // R1 zero -> EQ
    runOp(3, 64'h0, 64'h0, 16'h0, 1'b1, 1'b1);                            // R1 NAND negative, SO copy
    runOp(5, 64'h1234, 64'h1234, 16'h0, 1'b1, 1'b0);                      // R1 EQV equal -> all ones
    runOp(6, 64'h7F00_0000_0000_00FF, 64'h0F, 16'h0, 1'b0, 1'b0);         // R5 rc=0 no CR
    runOp(8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h8001, 1'b0, 1'b0);       // R6 ANDI with rc=0
    runOp(11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'hFFFF, 1'b0, 1'b1);      // R6 R3 ANDIS positive
    runOp(9, 64'h8000_0000_0000_0000, 64'h0, 16'hABCD, 1'b1, 1'b0);       // R7 ORI with rc=1
    runOp(13, 64'h0, 64'h0, 16'hFFFF, 1'b1, 1'b0);                        // R7 R3 XORIS
    runOp(14, 64'h0000_0000_0000_0080, 64'h0, 16'h0, 1'b1, 1'b0);         // R4 byte negative
    runOp(15, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0, 16'h0, 1'b1, 1'b0);         // R4 half positive
    runOp(16, 64'h0000_0000_8000_0000, 64'h0, 16'h0, 1'b1, 1'b0);         // R4 word negative
    runOp(31, 64'hFFFF, 64'hFFFF, 16'hFFFF, 1'b1, 1'b1);                  // R10 reserved
    idleCycle();                                                         // R9

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 20);
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: ;
        1: a = 64'h0;
        2: b = a;
        default: a = {{32{a[40]}}, a[31:0]} ^ 64'h0000_0000_8000_0080;
      endcase
      runOp(op, a, b, 16'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 9) == 0) idleCycle();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule